// File: doc/BRIEF.md
# Up/Down Pulse Counter with Latch

This block is one counter channel clocked by a 40 MHz system clock. It counts pulses that arrive on an asynchronous external pulse input. Each high-to-low transition of that input moves a 32-bit count by one. A separate direction input chooses between counting up and counting down. The pulse, direction and clear/latch inputs each pass through a two-stage synchronizer. Edges are found by comparing the newest synchronized sample with the one before it.

One external pin can do either of two jobs, chosen by a control register: it can zero the count, or it can copy the count into a 32-bit hold register. The pin does nothing until software sets an enable bit. Software can also copy the count into the hold register at any time through a strobe. The held value does not change between capture events. Software can therefore read it at two moments and subtract the two values to get the number of pulses in that interval.

Software reaches the block through a small register port. It has one write strobe, a 2-bit address, 2 bits of write data and a combinational 32-bit read data output.

Top module: `pulse_counter_latch`

## Requirements
- R1: After reset, the count, the hold register and the control register all read as zero.
- R2: A high-to-low transition on `pulse_in` while `dir_in` is high adds one to the count. The new value is readable within 4 system clock cycles. A low-to-high transition on `pulse_in` changes nothing.
- R3: A high-to-low transition on `pulse_in` while `dir_in` is low subtracts one from the count.
- R4: The count wraps modulo 2^32. Counting down from 0 gives 0xFFFFFFFF, and counting up from 0xFFFFFFFF gives 0.
- R5: A write to address 0 sets the control register. Bit 0 selects the pin function (0 = clear, 1 = latch) and bit 1 enables the pin. Reading address 0 returns these two bits, with all upper bits zero.
- R6: When bit 1 is set and bit 0 is clear, a rising edge on `ext_ctl_in` sets the count to zero.
- R7: When bits 1 and 0 are both set, a rising edge on `ext_ctl_in` copies the count into the hold register and leaves the count unchanged.
- R8: While bit 1 is clear, edges on `ext_ctl_in` change neither the count nor the hold register.
- R9: A write to address 1 with bit 0 set copies the count into the hold register. The hold register keeps its value until the next capture event.
- R10: When a clearing pin edge and a counting edge are detected in the same cycle, the clear wins and the count ends at zero.
- R11: Reading address 2 returns the count, reading address 3 returns the hold register, and reading address 1 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pulse_in | input | 1 | Asynchronous pulse input, counted on its falling edge |
| dir_in | input | 1 | Asynchronous direction input, high = count up |
| ext_ctl_in | input | 1 | Asynchronous clear/latch pin, acts on its rising edge |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for both reads and writes |
| reg_wdata | input | 2 | Register write data |
| reg_rdata | output | 32 | Read data for the register at `reg_addr` |

## Verification
A wrong count shows up at address 2 no later than the fourth system cycle after the pulse edge that caused it. Because the count accumulates, the error then stays visible on every later read. A hold register that is loaded when it should not be, or is not loaded when it should, shows up at address 3 on the read that follows the capture attempt. A pin that acts while it is disabled shows up as a count or held value that differs from the bench model on the read right after that pin pulse.

// File: rtl/pulse_counter_latch.sv
module pulse_counter_latch #(
  parameter int W    = 32,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pulse_in,
  input  logic         dir_in,
  input  logic         ext_ctl_in,
  input  logic         reg_we,
  input  logic [1:0]   reg_addr,
  input  logic [1:0]   reg_wdata,
  output logic [W-1:0] reg_rdata
);

  logic [SYNC:0]   pulse_pipe;
  logic [SYNC:0]   ctl_pipe;
  logic [SYNC-1:0] dir_pipe;
  logic            pin_latch_mode, pin_release;
  logic [W-1:0]    count_q, latch_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse_pipe <= '0;
      ctl_pipe   <= '0;
      dir_pipe   <= '0;
    end else begin
      pulse_pipe <= {pulse_pipe[SYNC-1:0], pulse_in};
      ctl_pipe   <= {ctl_pipe[SYNC-1:0], ext_ctl_in};
      dir_pipe   <= {dir_pipe[SYNC-2:0], dir_in};
    end
  end

  logic fall, rise, dir_s, clr_evt, lat_evt, sw_latch;
  assign fall     = pulse_pipe[SYNC] & ~pulse_pipe[SYNC-1];
  assign rise     = ctl_pipe[SYNC-1] & ~ctl_pipe[SYNC];
  assign dir_s    = dir_pipe[SYNC-1];
  assign sw_latch = reg_we && reg_addr == 2'd1 && reg_wdata[0];
  assign clr_evt  = rise && pin_release && !pin_latch_mode;
  assign lat_evt  = sw_latch || (rise && pin_release && pin_latch_mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_latch_mode <= 1'b0;
      pin_release    <= 1'b0;
    end else if (reg_we && reg_addr == 2'd0) begin
      pin_latch_mode <= reg_wdata[0];
      pin_release    <= reg_wdata[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       count_q <= '0;
    else if (clr_evt) count_q <= '0;
    else if (fall)    count_q <= dir_s ? count_q + W'(1) : count_q - W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       latch_q <= '0;
    else if (lat_evt) latch_q <= count_q;
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {{(W-2){1'b0}}, pin_release, pin_latch_mode};
      2'd2:    reg_rdata = count_q;
      2'd3:    reg_rdata = latch_q;
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/pulse_counter_latch_chk.sv
module pulse_counter_latch_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         fall,
  input logic         dir_s,
  input logic         clr_evt,
  input logic         lat_evt,
  input logic [W-1:0] count,
  input logic [W-1:0] latch_q
);

  assert_count_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && dir_s && !clr_evt) |=> count == $past(count) + W'(1));

  assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !dir_s && !clr_evt) |=> count == $past(count) - W'(1));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall && !clr_evt) |=> $stable(count));

  // clear outranks a simultaneous counting edge
  assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> count == '0);

  assert_latch_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lat_evt |=> latch_q == $past(count));

  assert_latch_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_evt |=> $stable(latch_q));

endmodule

bind pulse_counter_latch pulse_counter_latch_chk #(.W(W)) chk (
  .clk(clk), .rst_n(rst_n), .fall(fall), .dir_s(dir_s),
  .clr_evt(clr_evt), .lat_evt(lat_evt), .count(count_q), .latch_q(latch_q)
);

// File: tb/pulse_counter_latch_test.sv
module pulse_counter_latch_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        pulse_in = 1, dir_in = 1, ext_ctl_in = 0;
  logic        reg_we = 0;
  logic [1:0]  reg_addr = 0, reg_wdata = 0;
  logic [31:0] reg_rdata;

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [31:0] m_cnt = 0, m_lat = 0;
  logic        m_mode = 0, m_rel = 0;

  pulse_counter_latch uut (.*);

  always #2 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic wr(logic [1:0] a, logic [1:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
    if (a == 0) begin m_mode = d[0]; m_rel = d[1]; end
    if (a == 1 && d[0]) m_lat = m_cnt;
  endtask

  function automatic logic [31:0] step(logic [31:0] c, logic up);
    return up ? c + 32'd1 : c - 32'd1;
  endfunction

  task automatic pulse(logic up);
    @(negedge clk); dir_in = up; cyc(2);
    pulse_in = 0; cyc(4);
    m_cnt = step(m_cnt, up);
    pulse_in = 1; cyc(4);
  endtask

  task automatic pin_evt();
    @(negedge clk); ext_ctl_in = 1; cyc(5);
    ext_ctl_in = 0; cyc(5);
    if (m_rel) begin
      if (m_mode) m_lat = m_cnt; else m_cnt = 0;
    end
  endtask

  task automatic check_state(string req);
    logic [31:0] v;
    rd(2, v); check(req, v, m_cnt);
    rd(3, v); check(req, v, m_lat);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5eed1234));
    cyc(4); rst_n = 1; cyc(2);
    // R1 reset state
    rd(0, v); check("R1 ctrl", v, 0);
    rd(2, v); check("R1 count", v, 0);
    rd(3, v); check("R1 latch", v, 0);
    rd(1, v); check("R11 addr1 reads zero", v, 0);
    // R4 wrap down then up
    pulse(0); rd(2, v); check("R4 wrap down", v, 32'hFFFF_FFFF);
    pulse(1); rd(2, v); check("R4 wrap up", v, 0);
    // R2 / R3
    pulse(1); pulse(1); pulse(1); rd(2, v); check("R2 up", v, 3);
    pulse(0); rd(2, v); check("R3 down", v, 2);
    // R8 pin ignored when not released
    wr(0, 2'b00); pin_evt(); check_state("R8 pin disabled");
    wr(0, 2'b01); pin_evt(); check_state("R8 pin disabled latch mode");
    // R5 control readback
    wr(0, 2'b11); rd(0, v); check("R5 ctrl readback", v, 3);
    // R7 pin latch
    pin_evt(); check_state("R7 pin latch");
    // R9 software latch holds
    pulse(1); wr(1, 2'b01); check_state("R9 sw latch");
    pulse(1); pulse(1); rd(3, v); check("R9 latch holds", v, 3);
    wr(1, 2'b00); rd(3, v); check("R9 no strobe with bit0 clear", v, 3);
    // R6 pin clear
    wr(0, 2'b10); rd(0, v); check("R5 ctrl readback clear", v, 2);
    pin_evt(); check_state("R6 pin clear");
    // R10 clear and counting edge together
    pulse(1); pulse(1);
    @(negedge clk); dir_in = 1; cyc(2);
    pulse_in = 0; ext_ctl_in = 1; cyc(5);
    pulse_in = 1; ext_ctl_in = 0; cyc(5);
    m_cnt = 0;
    rd(2, v); check("R10 clear wins", v, 0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      int k = $urandom_range(0, 9);
      if (k < 6)       pulse(1'($urandom_range(0, 1)));
      else if (k == 6) wr(1, 2'($urandom_range(0, 3)));
      else if (k == 7) wr(0, 2'($urandom_range(0, 3)));
      else             pin_evt();
      check_state("R2 R3 R6 R7 R8 R9 random");
    end
    rd(0, v); check("R5 final ctrl", v, {30'b0, m_rel, m_mode});
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule